// File: doc/BRIEF.md
# Load/Store Unit with Alignment Checking

This block sits between a small processor's execute stage and a 16-bit memory bus. For each memory request it forms the effective address from a selected addressing mode, drives one bus transaction with the right byte enables and lane-placed write data, and returns read data, aligned and sign- or zero-extended, to the register file write port. Stack pushes and pops are handled here as well: the unit produces the updated stack pointer together with the transfer.

A request is offered with `req_valid` while `req_ready` is high and is taken on that clock edge. The unit then holds address, byte enables, write data and the read or write strobe steady until the slave answers with `bus_ack`. One cycle later it pulses `done`, with register and stack-pointer write strobes where they apply. A word transfer to an odd address never reaches the bus: the unit instead pulses `bus_err` together with `done`, and signals no writeback.

Top module: `ls_unit`

## Requirements
- R1: During and right after reset, `req_ready` is 1 and `bus_rd`, `bus_wr`, `done`, `bus_err`, `rd_we` and `sp_we` are 0.
- R2: The effective address on `bus_addr` follows `req_mode`: 0 = `base_val`, 1 = `imm_val`, 2 = `base_val + imm_val`, 3 = `pc_val + imm_val`, 4 (push) = `base_val - 2`, 5 (pop) = `base_val`, all modulo 2^16.
- R3: A word transfer (`req_word` = 1) drives `bus_be` = 2'b11, passes `req_wdata` unchanged to `bus_wdata`, and returns `bus_rdata` unchanged on `rd_data`.
- R4: A byte transfer uses big-endian lanes: an even address selects bits 15:8 with `bus_be` = 2'b10, an odd address selects bits 7:0 with `bus_be` = 2'b01; a byte store places `req_wdata[7:0]` on both lanes.
- R5: A byte read returns the selected lane in `rd_data[7:0]`; bits 15:8 copy bit 7 of that lane when `req_signed` = 1 and are 0 otherwise.
- R6: A word transfer to an odd effective address makes `bus_err` and `done` high for one cycle, the cycle after acceptance, with no `bus_rd`, `bus_wr`, `rd_we` or `sp_we` for that request.
- R7: From the cycle after acceptance until `bus_ack` is sampled, exactly one of `bus_rd`/`bus_wr` is high, `req_ready` is 0, and `bus_addr`, `bus_be` and `bus_wdata` hold their values regardless of later changes on the request inputs.
- R8: The cycle after `bus_ack` is sampled with a strobe high, `done` is 1 for exactly one cycle; for reads `rd_we` is 1 there with `rd_idx` equal to the accepted `req_idx`; for writes `rd_we` stays 0.
- R9: Push (mode 4) always writes a word and pop (mode 5) always reads a word, whatever `req_word` and `req_write` say; in the `done` cycle `sp_we` is 1 with `sp_data` = `base_val - 2` for push and `base_val + 2` for pop, and `sp_we` is 0 for every other mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_mode | input | 3 | Addressing mode select |
| req_write | input | 1 | 1 = store, 0 = load (modes 0 to 3) |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte (modes 0 to 3) |
| req_signed | input | 1 | Sign-extend a byte read |
| req_idx | input | 3 | Destination register index for a load |
| base_val | input | 16 | Base or stack register value |
| pc_val | input | 16 | Program counter value |
| imm_val | input | 16 | Immediate address or displacement |
| req_wdata | input | 16 | Store data |
| bus_addr | output | 16 | Bus byte address |
| bus_be | output | 2 | Byte enables, bit 1 = bits 15:8 |
| bus_wdata | output | 16 | Bus write data |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_ack | input | 1 | Slave acknowledge |
| bus_rdata | input | 16 | Slave read data, valid with bus_ack |
| done | output | 1 | One-cycle completion pulse |
| bus_err | output | 1 | Alignment fault pulse |
| rd_we | output | 1 | Register file write enable |
| rd_idx | output | 3 | Register file write index |
| rd_data | output | 16 | Aligned and extended load result |
| sp_we | output | 1 | Stack pointer write enable |
| sp_data | output | 16 | Updated stack pointer |

## Verification
The pairing that matters most is the alignment check landing in the same request as a stack pointer update: a push or pop with an odd stack value must fault and must also suppress the pointer write that would otherwise go out with `done`. Random stimulus leaves bit 0 of the base value free, so push and pop regularly meet odd stack values, and directed cases add an odd-stack push and a pop that wraps at the top of the address space. Each such request is judged in its completion cycle on `bus_err`, `sp_we` and the absence of any strobe, and the request after it must run normally.

// File: rtl/ls_pkg.sv
package ls_pkg;

   typedef enum logic [2:0] {
      AM_REG     = 3'd0,
      AM_ABS     = 3'd1,
      AM_REG_OFS = 3'd2,
      AM_PC_OFS  = 3'd3,
      AM_PUSH    = 3'd4,
      AM_POP     = 3'd5
   } amode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_BUS   = 2'd1,
      ST_DONE  = 2'd2,
      ST_FAULT = 2'd3
   } lsu_state_e;

endpackage

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
   import ls_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int STACK_STEP = 2
) (
   input  logic [2:0]        mode,
   input  logic              write_in,
   input  logic              word_in,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] pc,
   input  logic [ADDR_W-1:0] imm,
   output logic [ADDR_W-1:0] ea,
   output logic [ADDR_W-1:0] sp_next,
   output logic              sp_upd,
   output logic              eff_write,
   output logic              eff_word,
   output logic              misalign
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STACK_STEP);

   logic [ADDR_W-1:0] sum_base;
   logic [ADDR_W-1:0] sum_pc;
   logic [ADDR_W-1:0] sp_dec;
   logic [ADDR_W-1:0] sp_inc;

   assign sum_base = base + imm;
   assign sum_pc   = pc + imm;
   assign sp_dec   = base - STEP;
   assign sp_inc   = base + STEP;

   always_comb begin
      ea        = base;
      sp_next   = base;
      sp_upd    = 1'b0;
      eff_write = write_in;
      eff_word  = word_in;
      case (mode)
         AM_REG:     ea = base;
         AM_ABS:     ea = imm;
         AM_REG_OFS: ea = sum_base;
         AM_PC_OFS:  ea = sum_pc;
         AM_PUSH: begin
            ea        = sp_dec;
            sp_next   = sp_dec;
            sp_upd    = 1'b1;
            eff_write = 1'b1;
            eff_word  = 1'b1;
         end
         AM_POP: begin
            ea        = base;
            sp_next   = sp_inc;
            sp_upd    = 1'b1;
            eff_write = 1'b0;
            eff_word  = 1'b1;
         end
         default:    ea = base;
      endcase
   end

   assign misalign = eff_word & ea[0];

endmodule

// File: rtl/ls_lane_pack.sv
module ls_lane_pack #(
   parameter int DATA_W     = 16,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic              word,
   input  logic              a0,
   input  logic [DATA_W-1:0] wdata_in,
   output logic [1:0]        be,
   output logic [DATA_W-1:0] wdata_out
);

   localparam int BYTE_W = DATA_W / 2;

   logic hi_sel;

   generate
      if (BIG_ENDIAN) begin : g_big
         assign hi_sel = ~a0;
      end else begin : g_little
         assign hi_sel = a0;
      end
   endgenerate

   always_comb begin
      if (word) begin
         be        = 2'b11;
         wdata_out = wdata_in;
      end else begin
         be        = hi_sel ? 2'b10 : 2'b01;
         wdata_out = {wdata_in[BYTE_W-1:0], wdata_in[BYTE_W-1:0]};
      end
   end

endmodule

// File: rtl/ls_read_align.sv
module ls_read_align #(
   parameter int DATA_W     = 16,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic              word,
   input  logic              a0,
   input  logic              sgn,
   input  logic [DATA_W-1:0] raw,
   output logic [DATA_W-1:0] result
);

   localparam int BYTE_W = DATA_W / 2;

   logic              hi_sel;
   logic [BYTE_W-1:0] lane;

   generate
      if (BIG_ENDIAN) begin : g_big
         assign hi_sel = ~a0;
      end else begin : g_little
         assign hi_sel = a0;
      end
   endgenerate

   assign lane = hi_sel ? raw[DATA_W-1:BYTE_W] : raw[BYTE_W-1:0];

   always_comb begin
      if (word) begin
         result = raw;
      end else if (sgn) begin
         result = {{BYTE_W{lane[BYTE_W-1]}}, lane};
      end else begin
         result = {{BYTE_W{1'b0}}, lane};
      end
   end

endmodule

// File: rtl/ls_unit.sv
module ls_unit
   import ls_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 16,
   parameter int IDX_W      = 3,
   parameter int STACK_STEP = 2,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [2:0]        req_mode,
   input  logic              req_write,
   input  logic              req_word,
   input  logic              req_signed,
   input  logic [IDX_W-1:0]  req_idx,
   input  logic [ADDR_W-1:0] base_val,
   input  logic [ADDR_W-1:0] pc_val,
   input  logic [ADDR_W-1:0] imm_val,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [1:0]        bus_be,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              bus_rd,
   output logic              bus_wr,
   input  logic              bus_ack,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              done,
   output logic              bus_err,
   output logic              rd_we,
   output logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic              sp_we,
   output logic [ADDR_W-1:0] sp_data
);

   generate
      if (DATA_W % 2 != 0 || DATA_W < 4) begin : g_bad_data_w
         $error("ls_unit: DATA_W must be even and at least 4");
      end
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("ls_unit: ADDR_W must be at least 2");
      end
      if (STACK_STEP % 2 != 0) begin : g_bad_step
         $error("ls_unit: STACK_STEP must keep word alignment");
      end
   endgenerate

   // Request-side combinational path
   logic [ADDR_W-1:0] ea_c;
   logic [ADDR_W-1:0] sp_next_c;
   logic              sp_upd_c;
   logic              write_c;
   logic              word_c;
   logic              misalign_c;
   logic [1:0]        be_c;
   logic [DATA_W-1:0] wd_c;

   ls_addr_gen #(
      .ADDR_W     (ADDR_W),
      .STACK_STEP (STACK_STEP)
   ) u_agen (
      .mode      (req_mode),
      .write_in  (req_write),
      .word_in   (req_word),
      .base      (base_val),
      .pc        (pc_val),
      .imm       (imm_val),
      .ea        (ea_c),
      .sp_next   (sp_next_c),
      .sp_upd    (sp_upd_c),
      .eff_write (write_c),
      .eff_word  (word_c),
      .misalign  (misalign_c)
   );

   ls_lane_pack #(
      .DATA_W     (DATA_W),
      .BIG_ENDIAN (BIG_ENDIAN)
   ) u_pack (
      .word      (word_c),
      .a0        (ea_c[0]),
      .wdata_in  (req_wdata),
      .be        (be_c),
      .wdata_out (wd_c)
   );

   // Held transaction state
   lsu_state_e        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [1:0]        be_q;
   logic [DATA_W-1:0] wd_q;
   logic              write_q;
   logic              word_q;
   logic              sgn_q;
   logic [IDX_W-1:0]  idx_q;
   logic              sp_upd_q;
   logic [ADDR_W-1:0] sp_next_q;
   logic [DATA_W-1:0] rdata_q;

   logic accept;
   assign accept = req_valid & (state_q == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         case (state_q)
            ST_IDLE:  if (accept) state_q <= misalign_c ? ST_FAULT : ST_BUS;
            ST_BUS:   if (bus_ack) state_q <= ST_DONE;
            ST_DONE:  state_q <= ST_IDLE;
            ST_FAULT: state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q    <= '0;
         be_q      <= '0;
         wd_q      <= '0;
         write_q   <= 1'b0;
         word_q    <= 1'b0;
         sgn_q     <= 1'b0;
         idx_q     <= '0;
         sp_upd_q  <= 1'b0;
         sp_next_q <= '0;
      end else if (accept) begin
         addr_q    <= ea_c;
         be_q      <= be_c;
         wd_q      <= wd_c;
         write_q   <= write_c;
         word_q    <= word_c;
         sgn_q     <= req_signed;
         idx_q     <= req_idx;
         sp_upd_q  <= sp_upd_c;
         sp_next_q <= sp_next_c;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (state_q == ST_BUS && bus_ack && !write_q) begin
         rdata_q <= bus_rdata;
      end
   end

   // Read return path
   ls_read_align #(
      .DATA_W     (DATA_W),
      .BIG_ENDIAN (BIG_ENDIAN)
   ) u_align (
      .word   (word_q),
      .a0     (addr_q[0]),
      .sgn    (sgn_q),
      .raw    (rdata_q),
      .result (rd_data)
   );

   // Outputs
   assign req_ready = (state_q == ST_IDLE);
   assign bus_addr  = addr_q;
   assign bus_be    = be_q;
   assign bus_wdata = wd_q;
   assign bus_rd    = (state_q == ST_BUS) & ~write_q;
   assign bus_wr    = (state_q == ST_BUS) &  write_q;
   assign done      = (state_q == ST_DONE) | (state_q == ST_FAULT);
   assign bus_err   = (state_q == ST_FAULT);
   assign rd_we     = (state_q == ST_DONE) & ~write_q;
   assign rd_idx    = idx_q;
   assign sp_we     = (state_q == ST_DONE) & sp_upd_q;
   assign sp_data   = sp_next_q;

endmodule

// File: rtl/ls_unit_chk.sv
module ls_unit_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [1:0]        bus_be,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic              bus_ack,
   input logic              done,
   input logic              bus_err,
   input logic              rd_we,
   input logic              sp_we
);

   // R7: a single strobe kind at a time
   a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr));

   // R7: busy unit refuses new work
   a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd || bus_wr) |-> !req_ready);

   // R7: read held until acknowledged
   a_r7_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_ack) |=> (bus_rd && $stable(bus_addr) && $stable(bus_be)));

   // R7: write held until acknowledged
   a_r7_hold_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_ack) |=> (bus_wr && $stable(bus_addr) && $stable(bus_be)
                                && $stable(bus_wdata)));

   // R3: an active transfer enables at least one lane
   a_r3_lane_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd || bus_wr) |-> (bus_be != 2'b00));

   // R8: acknowledge leads to a clean completion
   a_r8_ack_then_done: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_rd || bus_wr) && bus_ack) |=> (done && !bus_err && !bus_rd && !bus_wr));

   // R8: completion lasts one cycle
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: register write only on completion
   a_r8_rdwe_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      rd_we |-> done);

   // R9: stack pointer write only on completion
   a_r9_spwe_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      sp_we |-> (done && !bus_err));

   // R6: a fault issues nothing
   a_r6_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> (done && !bus_rd && !bus_wr && !rd_we && !sp_we));

endmodule

bind ls_unit ls_unit_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .bus_addr  (bus_addr),
   .bus_be    (bus_be),
   .bus_wdata (bus_wdata),
   .bus_rd    (bus_rd),
   .bus_wr    (bus_wr),
   .bus_ack   (bus_ack),
   .done      (done),
   .bus_err   (bus_err),
   .rd_we     (rd_we),
   .sp_we     (sp_we)
);

// File: tb/ls_unit_test.sv
module ls_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [2:0]  req_mode = '0;
   logic        req_write = 1'b0;
   logic        req_word = 1'b0;
   logic        req_signed = 1'b0;
   logic [2:0]  req_idx = '0;
   logic [15:0] base_val = '0;
   logic [15:0] pc_val = '0;
   logic [15:0] imm_val = '0;
   logic [15:0] req_wdata = '0;
   logic [15:0] bus_addr;
   logic [1:0]  bus_be;
   logic [15:0] bus_wdata;
   logic        bus_rd;
   logic        bus_wr;
   logic        bus_ack = 1'b0;
   logic [15:0] bus_rdata = '0;
   logic        done;
   logic        bus_err;
   logic        rd_we;
   logic [2:0]  rd_idx;
   logic [15:0] rd_data;
   logic        sp_we;
   logic [15:0] sp_data;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   ls_unit uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_mode(req_mode), .req_write(req_write), .req_word(req_word),
      .req_signed(req_signed), .req_idx(req_idx), .base_val(base_val),
      .pc_val(pc_val), .imm_val(imm_val), .req_wdata(req_wdata),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
      .done(done), .bus_err(bus_err), .rd_we(rd_we), .rd_idx(rd_idx),
      .rd_data(rd_data), .sp_we(sp_we), .sp_data(sp_data)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=finish", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // Expected-value model (R2, R9)
   function automatic logic [15:0] m_addr(input logic [2:0] m, input logic [15:0] b,
                                          input logic [15:0] p, input logic [15:0] i);
      case (m)
         3'd1:    return i;
         3'd2:    return b + i;
         3'd3:    return p + i;
         3'd4:    return b - 16'd2;
         default: return b;
      endcase
   endfunction

   // R5, R3
   function automatic logic [15:0] m_rdata(input bit wd, input bit a0, input bit sg,
                                           input logic [15:0] raw);
      logic [7:0] lane;
      if (wd) return raw;
      lane = a0 ? raw[7:0] : raw[15:8];
      return sg ? {{8{lane[7]}}, lane} : {8'h00, lane};
   endfunction

   task automatic run_txn(input logic [2:0] m, input bit wr, input bit wd, input bit sg,
                          input logic [15:0] b, input logic [15:0] p, input logic [15:0] i,
                          input logic [15:0] wdat, input logic [2:0] idx,
                          input logic [15:0] rdat, input int lat);
      logic [15:0] ea;
      bit          e_wr;
      bit          e_wd;
      bit          is_stack;
      bit          fault;
      logic [1:0]  e_be;
      logic [15:0] e_wdata;
      ea       = m_addr(m, b, p, i);
      is_stack = (m == 3'd4) || (m == 3'd5);
      e_wr     = (m == 3'd4) ? 1'b1 : (m == 3'd5) ? 1'b0 : wr;
      e_wd     = is_stack ? 1'b1 : wd;
      fault    = e_wd && ea[0];
      e_be     = e_wd ? 2'b11 : (ea[0] ? 2'b01 : 2'b10);
      e_wdata  = e_wd ? wdat : {wdat[7:0], wdat[7:0]};

      @(negedge clk);
      chk(req_ready == 1'b1, "R7 ready before request", 32'(req_ready), 32'd1);
      req_mode = m; req_write = wr; req_word = wd; req_signed = sg; req_idx = idx;
      base_val = b; pc_val = p; imm_val = i; req_wdata = wdat; req_valid = 1'b1;
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      // scramble request inputs to show the held values do not follow them (R7)
      base_val = 16'($urandom); pc_val = 16'($urandom); imm_val = 16'($urandom);
      req_wdata = 16'($urandom); req_word = 1'($urandom); req_mode = 3'($urandom);
      req_signed = 1'($urandom); req_idx = 3'($urandom);
      @(negedge clk);
      if (fault) begin
         chk(bus_err == 1'b1 && done == 1'b1, "R6 fault pulse", {bus_err, done}, 2'b11);
         chk(!bus_rd && !bus_wr, "R6 no strobe on fault", {bus_rd, bus_wr}, 2'b00);
         chk(!rd_we && !sp_we, "R6 no writeback on fault", {rd_we, sp_we}, 2'b00);
         @(negedge clk);
         chk(!bus_err && !done && req_ready, "R6 fault lasts one cycle",
             {bus_err, done, req_ready}, 3'b001);
         return;
      end
      for (int k = 0; k <= lat; k++) begin
         chk(bus_addr == ea, "R2 effective address", bus_addr, ea);
         chk(bus_be == e_be, e_wd ? "R3 word enables" : "R4 byte lane enables",
             bus_be, e_be);
         chk(bus_rd == !e_wr && bus_wr == e_wr, "R7 strobe held", {bus_rd, bus_wr},
             {!e_wr, e_wr});
         chk(!done && !req_ready, "R7 busy until ack", {done, req_ready}, 2'b00);
         if (e_wr)
            chk(bus_wdata == e_wdata, e_wd ? "R3 word write data" : "R4 byte replicate",
                bus_wdata, e_wdata);
         if (k == lat) begin
            bus_ack = 1'b1;
            bus_rdata = rdat;
         end
         @(posedge clk);
         #1;
         bus_ack = 1'b0;
         bus_rdata = 16'($urandom);
         @(negedge clk);
      end
      chk(done && !bus_err && !bus_rd && !bus_wr, "R8 done after ack",
          {done, bus_err, bus_rd, bus_wr}, 4'b1000);
      chk(rd_we == !e_wr, "R8 register write enable", 32'(rd_we), 32'(!e_wr));
      if (!e_wr) begin
         chk(rd_idx == idx, "R8 register index", 32'(rd_idx), 32'(idx));
         chk(rd_data == m_rdata(e_wd, ea[0], sg, rdat),
             e_wd ? "R3 word read data" : "R5 byte extension",
             rd_data, m_rdata(e_wd, ea[0], sg, rdat));
      end
      chk(sp_we == is_stack, "R9 stack pointer write", 32'(sp_we), 32'(is_stack));
      if (is_stack)
         chk(sp_data == ((m == 3'd4) ? b - 16'd2 : b + 16'd2), "R9 stack pointer value",
             sp_data, (m == 3'd4) ? b - 16'd2 : b + 16'd2);
      @(negedge clk);
      chk(!done && req_ready, "R8 done is one pulse", {done, req_ready}, 2'b01);
   endtask

   initial begin
      int unsigned seed_init;
      seed_init = $urandom(32'd4242);
      // R1 reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(req_ready && !bus_rd && !bus_wr && !done && !bus_err && !rd_we && !sp_we,
          "R1 in reset", {req_ready, bus_rd, bus_wr, done, bus_err, rd_we, sp_we},
          7'b1000000);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !bus_rd && !bus_wr && !done && !bus_err,
          "R1 after reset", {req_ready, bus_rd, bus_wr, done, bus_err}, 5'b10000);

      // Directed corners
      run_txn(3'd0, 1'b0, 1'b0, 1'b1, 16'h1000, 16'h0, 16'h0, 16'h0, 3'd1, 16'h80_11, 0); // R4 R5 even signed
      run_txn(3'd0, 1'b0, 1'b0, 1'b1, 16'h1001, 16'h0, 16'h0, 16'h0, 3'd2, 16'h11_F0, 2); // R5 odd signed
      run_txn(3'd0, 1'b0, 1'b0, 1'b0, 16'h1001, 16'h0, 16'h0, 16'h0, 3'd3, 16'h11_F0, 1); // R5 odd unsigned
      run_txn(3'd1, 1'b1, 1'b0, 1'b0, 16'h0, 16'h0, 16'h2003, 16'hABCD, 3'd0, 16'h0, 0);  // R4 byte store odd
      run_txn(3'd3, 1'b0, 1'b1, 1'b0, 16'h0, 16'hFFF0, 16'h0020, 16'h0, 3'd4, 16'h1234, 3); // R2 PC wrap
      run_txn(3'd2, 1'b1, 1'b1, 1'b0, 16'h3000, 16'h0, 16'h0005, 16'h5555, 3'd0, 16'h0, 0); // R6 odd word
      run_txn(3'd4, 1'b0, 1'b0, 1'b0, 16'h4001, 16'h0, 16'h0, 16'h7777, 3'd0, 16'h0, 0);  // R6 R9 odd push
      run_txn(3'd5, 1'b1, 1'b0, 1'b0, 16'h4003, 16'h0, 16'h0, 16'h0, 3'd5, 16'h0, 0);     // R6 R9 odd pop
      run_txn(3'd4, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0, 16'h0, 16'hBEEF, 3'd0, 16'h0, 1);  // R9 push wrap
      run_txn(3'd5, 1'b1, 1'b0, 1'b1, 16'hFFFE, 16'h0, 16'h0, 16'h0, 3'd6, 16'h8001, 2);  // R9 pop wrap

      // Constrained random mix
      for (int n = 0; n < 400; n++) begin
         run_txn(3'($urandom_range(0, 5)), 1'($urandom), 1'($urandom), 1'($urandom),
                 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                 3'($urandom), 16'($urandom), $urandom_range(0, 3));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule